// File: doc/BRIEF.md
# Triggered Integration Gate Generator

This block drives a set of integration gates for charge digitizers from one shared trigger. Each rising edge of the trigger opens every gate that is currently closed. Each gate then stays open for a fixed base of 25 ticks plus its own programmable extension. One clock cycle of a fast clock counts as one tick, so a 1 GHz clock gives 1 ns steps. Each gate has its own 8-bit width code, and the code is captured at the moment the gate opens.

The trigger is treated as a level that is synchronous to the clock. The first cycle in which it is seen high after being low counts as the edge. A gate that is already open ignores further edges. Its width code may be changed while it is open without affecting the gate that is running.

Top module: `gate_pulse_gen`

## Requirements
- R1: While reset is high, and in the cycle after it is released, every gate output is low.
- R2: If the trigger is sampled high at a clock edge and was sampled low at the previous edge, every gate that is closed goes high right after that edge.
- R3: With a width code x in the range 1 to 255, the gate stays high for exactly 25 + x clock cycles and then goes low.
- R4: A width code of 0 behaves as a code of 1, which gives a gate 26 cycles long.
- R5: Each gate uses only its own width code. The code for gate g sits in bits [8g+7:8g] of the width bus. Gates with different codes opened by the same edge close at different times.
- R6: A trigger rising edge that arrives while a gate is high neither restarts that gate nor makes it longer.
- R7: The width code is captured at the opening edge. Changing it while the gate is high does not change that gate's length.
- R8: Holding the trigger high does not open a new gate after the current one closes. Only a low-to-high transition opens a gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous reset, active high |
| trigIn | input | 1 | Shared trigger level, synchronous to clk |
| widthCode | input | NUM_GATES*8 | Width codes, gate g in bits [8g+7:8g] |
| gateOut | output | NUM_GATES | Gate outputs, active high |

## Verification
The assertions assume that the trigger is already synchronous to the clock. They also assume it is low while reset is asserted, so that the first edge after reset is seen as a rise. The stimulus changes the trigger and the width codes only on the falling clock edge. It holds the trigger low throughout reset. The random phase draws trigger levels and codes that include 0 and 255, and it reloads codes while gates are open, so the capture rule is exercised under mixed timing.

// File: rtl/gate_pulse_gen_pkg.sv
package gate_pulse_gen_pkg;

  typedef struct packed {
    logic fire;   // trigger rising edge seen this cycle
  } ctrlStrobes_t;

  // width code 0 is promoted to 1
  function automatic int unsigned effCode(input int unsigned code);
    return (code == 0) ? 1 : code;
  endfunction

endpackage

// File: rtl/gate_pulse_gen_ctrl.sv
module gate_pulse_gen_ctrl
  import gate_pulse_gen_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         trigIn,
  output ctrlStrobes_t strobes
);

  logic trigPrev;

  always_ff @(posedge clk) begin
    if (rst) trigPrev <= 1'b0;
    else     trigPrev <= trigIn;
  end

  always_comb strobes.fire = trigIn & ~trigPrev;

endmodule

// File: rtl/gate_pulse_gen_dp.sv
module gate_pulse_gen_dp
  import gate_pulse_gen_pkg::*;
#(
  parameter int NUM_GATES  = 2,
  parameter int CODE_W     = 8,
  parameter int BASE_TICKS = 25
) (
  input  logic                        clk,
  input  logic                        rst,
  input  ctrlStrobes_t                strobes,
  input  logic [NUM_GATES*CODE_W-1:0] widthCode,
  output logic [NUM_GATES-1:0]        gateOut
);

  localparam int MAX_LEN = BASE_TICKS + (1 << CODE_W) - 1;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  for (genvar g = 0; g < NUM_GATES; g++) begin : gGate
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  loadVal;
    logic [CNT_W-1:0]  remain;
    logic              isOpen;

    assign code = widthCode[g*CODE_W +: CODE_W];

    // remaining cycles after the first one
    always_comb loadVal = CNT_W'(BASE_TICKS - 1) + CNT_W'(effCode(32'(code)));

    always_ff @(posedge clk) begin
      if (rst) begin
        isOpen <= 1'b0;
        remain <= '0;
      end else if (strobes.fire && !isOpen) begin
        isOpen <= 1'b1;
        remain <= loadVal;
      end else if (isOpen) begin
        if (remain == '0) isOpen <= 1'b0;
        else              remain <= remain - 1'b1;
      end
    end

    assign gateOut[g] = isOpen;
  end

endmodule

// File: rtl/gate_pulse_gen.sv
module gate_pulse_gen
  import gate_pulse_gen_pkg::*;
#(
  parameter int NUM_GATES  = 2,
  parameter int CODE_W     = 8,
  parameter int BASE_TICKS = 25
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        trigIn,
  input  logic [NUM_GATES*CODE_W-1:0] widthCode,
  output logic [NUM_GATES-1:0]        gateOut
);

  ctrlStrobes_t strobes;

  gate_pulse_gen_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .trigIn  (trigIn),
    .strobes (strobes)
  );

  gate_pulse_gen_dp #(
    .NUM_GATES  (NUM_GATES),
    .CODE_W     (CODE_W),
    .BASE_TICKS (BASE_TICKS)
  ) uDp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .widthCode (widthCode),
    .gateOut   (gateOut)
  );

endmodule

// File: rtl/gate_pulse_gen_chk.sv
module gate_pulse_gen_chk #(
  parameter int NUM_GATES  = 2,
  parameter int CODE_W     = 8,
  parameter int BASE_TICKS = 25
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 trigIn,
  input logic [NUM_GATES-1:0] gateOut
);

  localparam int MAX_LEN = BASE_TICKS + (1 << CODE_W) - 1;
  localparam int HC_W    = $clog2(MAX_LEN + 2);

  assert_reset_low_R1: assert property (@(posedge clk) rst |=> (gateOut == '0));

  for (genvar g = 0; g < NUM_GATES; g++) begin : gChk
    logic [HC_W-1:0] hiCnt;

    always_ff @(posedge clk) begin
      if (rst)             hiCnt <= '0;
      else if (gateOut[g]) hiCnt <= hiCnt + 1'b1;
      else                 hiCnt <= '0;
    end

    assert_open_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
      ($rose(trigIn) && !gateOut[g]) |=> gateOut[g]);

    assert_len_max_R3: assert property (@(posedge clk) disable iff (rst)
      gateOut[g] |-> (32'(hiCnt) < MAX_LEN));

    assert_len_min_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(gateOut[g]) |-> (32'(hiCnt) >= BASE_TICKS + 1));

    assert_level_no_fire_R8: assert property (@(posedge clk) disable iff (rst)
      ($stable(trigIn) && !gateOut[g]) |=> !gateOut[g]);
  end

endmodule

bind gate_pulse_gen gate_pulse_gen_chk #(
  .NUM_GATES  (NUM_GATES),
  .CODE_W     (CODE_W),
  .BASE_TICKS (BASE_TICKS)
) uChk (
  .clk     (clk),
  .rst     (rst),
  .trigIn  (trigIn),
  .gateOut (gateOut)
);

// File: tb/tb_gate_pulse_gen.sv
module tb_gate_pulse_gen;
  localparam int CLK_PERIOD = 10;
  localparam int N = 2;
  localparam int CW = 8;
  localparam int BASE = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trigIn = 1'b0;
  logic [N*CW-1:0] widthCode = '0;
  logic [N-1:0] gateOut;

  int checks = 0;
  int errors = 0;
  int remM [N];
  bit prevM = 1'b0;
  int cnt [N];
  int rises [N];
  bit done = 1'b0;

  gate_pulse_gen #(.NUM_GATES(N), .CODE_W(CW), .BASE_TICKS(BASE)) dut (
    .clk(clk), .rst(rst), .trigIn(trigIn), .widthCode(widthCode), .gateOut(gateOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int expLen(input int code);
    return BASE + ((code == 0) ? 1 : code);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at a falling edge, predict the next rising edge, compare at the next falling edge
  task automatic step(input bit t, input logic [N*CW-1:0] w, input string tag);
    trigIn = t;
    widthCode = w;
    for (int g = 0; g < N; g++) begin
      if (t && !prevM && remM[g] == 0) remM[g] = expLen(int'(w[g*CW +: CW]));
      else if (remM[g] > 0) remM[g]--;
    end
    prevM = t;
    @(negedge clk);
    for (int g = 0; g < N; g++) check(tag, int'(gateOut[g]), int'(remM[g] != 0));
  endtask

  // mode 0 plain, 1 retrigger mid gate, 2 change codes mid gate, 3 hold trigger high
  task automatic burst(input int c0, input int c1, input int mode, input string tag);
    logic [N*CW-1:0] w;
    logic [N-1:0] prev;
    w = {CW'(c1), CW'(c0)};
    prev = gateOut;
    for (int g = 0; g < N; g++) begin cnt[g] = 0; rises[g] = 0; end
    step(1'b0, w, tag);
    for (int i = 0; i < 320; i++) begin
      bit t;
      logic [N*CW-1:0] wi;
      t = (i == 0) || (mode == 1 && (i == 10 || i == 11)) || (mode == 3);
      wi = (mode == 2 && i > 0) ? ~w : w;
      step(t, wi, tag);
      for (int g = 0; g < N; g++) begin
        if (gateOut[g]) cnt[g]++;
        if (gateOut[g] && !prev[g]) rises[g]++;
      end
      prev = gateOut;
    end
    step(1'b0, w, tag);
    check({tag, " len g0"}, cnt[0], expLen(c0));
    check({tag, " len g1"}, cnt[1], expLen(c1));
    check({tag, " rises g0"}, rises[0], 1);
    check({tag, " rises g1"}, rises[1], 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int g = 0; g < N; g++) remM[g] = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", int'(gateOut), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", int'(gateOut), 0);

    burst(1, 255, 0, "R3 extremes");
    burst(100, 7, 0, "R5 independent");
    burst(0, 0, 0, "R4 zero code");
    burst(40, 90, 1, "R6 retrigger");
    burst(30, 200, 2, "R7 mid change");
    burst(5, 60, 3, "R8 held high");
    burst(12, 13, 0, "R2 open");

    for (int i = 0; i < 15000; i++) begin
      logic [N*CW-1:0] w;
      for (int g = 0; g < N; g++) begin
        int r = $urandom % 10;
        w[g*CW +: CW] = (r == 0) ? 8'd0 : (r == 1) ? 8'd255 : CW'($urandom % 64);
      end
      step(($urandom % 6) == 0, w, "R2 R3 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule